// File: doc/BRIEF.md
# Bit-Stream Pseudowire Packet Header Builder

This block is the transmit half of a link that carries a raw client bit-stream across a packet network. Client data arrives as a stream of bytes or wider words. The block cuts the stream into payloads of a fixed size. In front of each payload it places a 16-byte header: a 4-byte control word followed by a 12-byte real-time transport header. The result leaves on a streaming packet interface with valid, ready and last signals. The outer network headers are added by a later stage.

The control word has two flags. One flag reports a fault on the client signal. The other reports that the local receive side has lost packets or is degraded. The control word also holds a 16-bit sequence number that advances once per packet. The transport header carries version 2 and the same sequence number. It also carries a payload type and a source identifier, both taken from configuration inputs. Its timestamp is sampled from a free-running common-clock counter. The timestamp and both flags are captured when the first payload word of a packet is accepted. That word is held inside the block while the header is sent out.

Backpressure on the output stalls the client input through its ready signal. No client data is dropped and none is reordered.

Top module: `pwe_hdr_builder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The first packet carries sequence number `SEQ_INIT`.
- R2: Control-word bits 0-3 are 0000, counting bit 0 as the first transmitted bit (output word bits 31:28 when `DATA_W`=32). Control-word bits 6-15 are always 0.
- R3: Control-word bit 4 (word bit 27) equals `client_fault` as sampled on the clock edge that accepts the packet's first payload word. Later changes of `client_fault` do not alter that packet.
- R4: Control-word bit 5 (word bit 26) equals `loss_state`, sampled on the same edge as in R3.
- R5: Control-word bits 16-31 (word bits 15:0) hold the sequence number. It rises by one per packet and wraps from 0xFFFF to 0x0000.
- R6: Header bytes 4-7 read {2'b10, seven zero bits, `cfg_pt`, sequence number}. This encodes version 2, zero padding, extension, source-count and marker fields, and the same sequence value as the control word.
- R7: Header bytes 8-11 hold `ts_count` as sampled on the edge that accepts the first payload word. Header bytes 12-15 hold `cfg_ssrc`.
- R8: Each packet carries exactly `PAYLOAD_BYTES` client bytes, unchanged and in arrival order. Bytes are packed big-endian: the earliest byte sits in the most significant byte of each word.
- R9: `out_last` is 1 on the final word of each packet and 0 on every other word. A packet is 16 + `PAYLOAD_BYTES` bytes long.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold steady. No input word is accepted while the output is stalled, and no input word is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DATA_W | Client stream word, earliest byte in the most significant byte |
| in_valid | input | 1 | Client word present |
| in_ready | output | 1 | Block takes the client word on this edge |
| client_fault | input | 1 | Client-signal fault state |
| loss_state | input | 1 | Local receive side in packet-loss or degraded state |
| ts_count | input | 32 | Free-running common-clock timestamp counter |
| cfg_pt | input | 7 | Payload type value |
| cfg_ssrc | input | 32 | Source identifier value |
| out_data | output | DATA_W | Packet word |
| out_valid | output | 1 | Packet word present |
| out_ready | input | 1 | Downstream takes the packet word |
| out_last | output | 1 | Final word of the packet |

## Verification
The assertions assume that `in_data` is a valid client stream. They also assume that `out_ready` may drop at any cycle without dropping `in_valid`. Finally, they assume that `cfg_pt` and `cfg_ssrc` do not change while a packet is being sent.

The stimulus changes configuration only between packets, with the block idle. It raises and lowers the flags only at clock midpoints. It drives input words at the falling edge and holds each word until the block takes it. Downstream stalls come from a fixed repeating pattern, and gaps between client words are inserted on purpose.

// File: rtl/pwe_hdr_pkg.sv
package pwe_hdr_pkg;

   localparam int HDR_BYTES = 16;
   localparam int HDR_BITS  = HDR_BYTES * 8;
   localparam int SEQ_W     = 16;
   localparam int TS_W      = 32;
   localparam int PT_W      = 7;
   localparam int SSRC_W    = 32;

   typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_FIRST, ST_PAY} state_t;
   typedef enum logic [1:0] {SRC_NONE, SRC_HDR, SRC_HOLD, SRC_IN} src_t;

   // Per-packet values captured with the first payload word
   typedef struct packed {
      logic            l_flag;
      logic            r_flag;
      logic [TS_W-1:0] ts;
   } pkt_meta_t;

   function automatic logic [HDR_BITS-1:0] build_hdr(
      input logic              l_flag,
      input logic              r_flag,
      input logic [SEQ_W-1:0]  seq,
      input logic [PT_W-1:0]   pt,
      input logic [TS_W-1:0]   ts,
      input logic [SSRC_W-1:0] ssrc
   );
      logic [31:0] ctl_word;
      logic [31:0] rtp_word;
      ctl_word = {4'b0000, l_flag, r_flag, 2'b00, 2'b00, 6'd0, seq};
      rtp_word = {2'b10, 1'b0, 1'b0, 4'd0, 1'b0, pt, seq};
      return {ctl_word, rtp_word, ts, ssrc};
   endfunction

endpackage

// File: rtl/pwe_hdr_seq.sv
module pwe_hdr_seq
   import pwe_hdr_pkg::*;
#(
   parameter logic [SEQ_W-1:0] SEQ_INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [SEQ_W-1:0] seq
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seq <= SEQ_INIT;
      end else if (adv) begin
         seq <= seq + SEQ_W'(1);
      end
   end

endmodule

// File: rtl/pwe_hdr_ctrl.sv
module pwe_hdr_ctrl
   import pwe_hdr_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int HDR_WORDS = 4,
   parameter int PAY_WORDS = 256,
   localparam int HIDX_W   = $clog2(HDR_WORDS),
   localparam int MAXW     = (HDR_WORDS > PAY_WORDS) ? HDR_WORDS : PAY_WORDS,
   localparam int CNT_W    = $clog2(MAXW) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              out_ready,
   input  logic              client_fault,
   input  logic              loss_state,
   input  logic [TS_W-1:0]   ts_count,
   output logic [DATA_W-1:0] hold_data,
   output pkt_meta_t         meta,
   output src_t              src,
   output logic [HIDX_W-1:0] hdr_idx,
   output logic              out_valid,
   output logic              out_last,
   output logic              seq_adv
);

   localparam bit ONE_WORD = (PAY_WORDS == 1);

   state_t           state;
   logic [CNT_W-1:0] cnt;
   logic             hdr_end;
   logic             pay_end;

   assign hdr_end = (cnt == CNT_W'(HDR_WORDS - 1));
   assign pay_end = (cnt == CNT_W'(PAY_WORDS - 1));
   assign hdr_idx = cnt[HIDX_W-1:0];

   always_comb begin
      in_ready  = 1'b0;
      out_valid = 1'b0;
      out_last  = 1'b0;
      seq_adv   = 1'b0;
      src       = SRC_NONE;
      case (state)
         ST_IDLE: begin
            in_ready = 1'b1;
         end
         ST_HDR: begin
            out_valid = 1'b1;
            src       = SRC_HDR;
         end
         ST_FIRST: begin
            out_valid = 1'b1;
            src       = SRC_HOLD;
            out_last  = ONE_WORD;
            seq_adv   = ONE_WORD && out_ready;
         end
         default: begin
            out_valid = in_valid;
            in_ready  = out_ready;
            src       = SRC_IN;
            out_last  = pay_end;
            seq_adv   = in_valid && out_ready && pay_end;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         hold_data <= '0;
         meta      <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (in_valid) begin
                  hold_data   <= in_data;
                  meta.l_flag <= client_fault;
                  meta.r_flag <= loss_state;
                  meta.ts     <= ts_count;
                  cnt         <= '0;
                  state       <= ST_HDR;
               end
            end
            ST_HDR: begin
               if (out_ready) begin
                  if (hdr_end) begin
                     cnt   <= '0;
                     state <= ST_FIRST;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
            end
            ST_FIRST: begin
               if (out_ready) begin
                  if (ONE_WORD) begin
                     state <= ST_IDLE;
                  end else begin
                     cnt   <= CNT_W'(1);
                     state <= ST_PAY;
                  end
               end
            end
            default: begin
               if (in_valid && out_ready) begin
                  if (pay_end) begin
                     state <= ST_IDLE;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/pwe_hdr_mux.sv
module pwe_hdr_mux
   import pwe_hdr_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int HDR_WORDS = 4,
   localparam int HIDX_W   = $clog2(HDR_WORDS)
) (
   input  src_t                src,
   input  logic [HIDX_W-1:0]   hdr_idx,
   input  logic [HDR_BITS-1:0] hdr,
   input  logic [DATA_W-1:0]   hold_data,
   input  logic [DATA_W-1:0]   in_data,
   output logic [DATA_W-1:0]   out_data
);

   logic [DATA_W-1:0] hdr_words [HDR_WORDS];
   logic [DATA_W-1:0] hdr_sel;

   // Header word 0 holds the first transmitted header bytes
   for (genvar w = 0; w < HDR_WORDS; w++) begin : g_slice
      assign hdr_words[w] = hdr[HDR_BITS-1-w*DATA_W -: DATA_W];
   end

   assign hdr_sel = hdr_words[hdr_idx];

   always_comb begin
      case (src)
         SRC_HDR:  out_data = hdr_sel;
         SRC_HOLD: out_data = hold_data;
         SRC_IN:   out_data = in_data;
         default:  out_data = '0;
      endcase
   end

endmodule

// File: rtl/pwe_hdr_builder.sv
module pwe_hdr_builder
   import pwe_hdr_pkg::*;
#(
   parameter int               DATA_W        = 32,
   parameter int               PAYLOAD_BYTES = 1024,
   parameter logic [SEQ_W-1:0] SEQ_INIT      = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              client_fault,
   input  logic              loss_state,
   input  logic [31:0]       ts_count,
   input  logic [6:0]        cfg_pt,
   input  logic [31:0]       cfg_ssrc,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_last
);

   localparam int HDR_WORDS = HDR_BITS / DATA_W;
   localparam int PAY_WORDS = (PAYLOAD_BYTES * 8) / DATA_W;
   localparam int HIDX_W    = $clog2(HDR_WORDS);

   if ((DATA_W < 8) || (DATA_W > 64) || (DATA_W % 8 != 0)
       || (HDR_BITS % DATA_W != 0)) begin : g_bad_width
      $error("pwe_hdr_builder: DATA_W must be 8, 16, 32 or 64");
   end
   if ((PAYLOAD_BYTES < 1) || ((PAYLOAD_BYTES * 8) % DATA_W != 0)) begin : g_bad_size
      $error("pwe_hdr_builder: PAYLOAD_BYTES must fill whole words");
   end

   logic [DATA_W-1:0]   hold_data;
   pkt_meta_t           meta;
   src_t                src;
   logic [HIDX_W-1:0]   hdr_idx;
   logic                seq_adv;
   logic [SEQ_W-1:0]    seq;
   logic [HDR_BITS-1:0] hdr;

   pwe_hdr_ctrl #(
      .DATA_W    (DATA_W),
      .HDR_WORDS (HDR_WORDS),
      .PAY_WORDS (PAY_WORDS)
   ) ctrl_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_data      (in_data),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .out_ready    (out_ready),
      .client_fault (client_fault),
      .loss_state   (loss_state),
      .ts_count     (ts_count),
      .hold_data    (hold_data),
      .meta         (meta),
      .src          (src),
      .hdr_idx      (hdr_idx),
      .out_valid    (out_valid),
      .out_last     (out_last),
      .seq_adv      (seq_adv)
   );

   pwe_hdr_seq #(
      .SEQ_INIT (SEQ_INIT)
   ) seq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (seq_adv),
      .seq   (seq)
   );

   assign hdr = build_hdr(meta.l_flag, meta.r_flag, seq, cfg_pt, meta.ts, cfg_ssrc);

   pwe_hdr_mux #(
      .DATA_W    (DATA_W),
      .HDR_WORDS (HDR_WORDS)
   ) mux_i (
      .src       (src),
      .hdr_idx   (hdr_idx),
      .hdr       (hdr),
      .hold_data (hold_data),
      .in_data   (in_data),
      .out_data  (out_data)
   );

endmodule

// File: rtl/pwe_hdr_builder_chk.sv
module pwe_hdr_builder_chk #(
   parameter int DATA_W        = 32,
   parameter int PAYLOAD_BYTES = 1024
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              out_valid,
   input logic              out_ready,
   input logic              out_last
);

   localparam int PKT_WORDS = ((16 + PAYLOAD_BYTES) * 8) / DATA_W;
   localparam int BPW       = DATA_W / 8;
   localparam int V_WORD    = 4 / BPW;
   localparam int V_BIT     = DATA_W - 1 - (4 % BPW) * 8;
   localparam int BW        = $clog2(PKT_WORDS) + 1;

   logic [BW-1:0] beat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat <= '0;
      end else if (out_valid && out_ready) begin
         beat <= (beat == BW'(PKT_WORDS - 1)) ? '0 : beat + BW'(1);
      end
   end

   a_r9_last_position: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |-> (out_last == (beat == BW'(PKT_WORDS - 1))));

   a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

   a_r10_no_take_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> (out_ready || !out_valid));

   a_r2_cw_nibble: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && beat == '0) |-> (out_data[DATA_W-1 -: 4] == 4'b0000));

   a_r6_version: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && beat == BW'(V_WORD)) |-> (out_data[V_BIT -: 2] == 2'b10));

endmodule

bind pwe_hdr_builder pwe_hdr_builder_chk #(
   .DATA_W        (DATA_W),
   .PAYLOAD_BYTES (PAYLOAD_BYTES)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_data  (out_data),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_last  (out_last)
);

// File: tb/pwe_hdr_builder_tb_top.sv
module pwe_hdr_builder_tb_top;

   localparam int          CLK_PERIOD = 10;
   localparam int          DW         = 32;
   localparam int          PB         = 16;
   localparam int          PAYW       = PB * 8 / DW;
   localparam int          PKTW       = (16 + PB) * 8 / DW;
   localparam logic [15:0] SEQ0       = 16'hFFFD;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic          client_fault = 1'b0;
   logic          loss_state = 1'b0;
   logic [31:0]   ts_count = 32'h1000_0000;
   logic [6:0]    cfg_pt = 7'd96;
   logic [31:0]   cfg_ssrc = 32'h1234_5678;
   logic [DW-1:0] out_data;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic          out_last;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;
   bit  stall_mode = 1'b0;
   int  stall_cnt = 0;

   logic [DW-1:0] cap_d [0:255];
   logic          cap_l [0:255];
   int            cap_n = 0;

   pwe_hdr_builder #(
      .DATA_W        (DW),
      .PAYLOAD_BYTES (PB),
      .SEQ_INIT      (SEQ0)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_data      (in_data),
      .in_valid     (in_valid),
      .in_ready     (in_ready),
      .client_fault (client_fault),
      .loss_state   (loss_state),
      .ts_count     (ts_count),
      .cfg_pt       (cfg_pt),
      .cfg_ssrc     (cfg_ssrc),
      .out_data     (out_data),
      .out_valid    (out_valid),
      .out_ready    (out_ready),
      .out_last     (out_last)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(negedge clk) begin
      ts_count  <= ts_count + 32'h11;
      stall_cnt <= stall_cnt + 1;
      out_ready <= stall_mode ? (stall_cnt % 3 != 0) : 1'b1;
   end

   always @(negedge clk) begin
      #1;
      if (rst_n && out_valid && out_ready) begin
         cap_d[cap_n] = out_data;
         cap_l[cap_n] = out_last;
         cap_n = cap_n + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] pay_word(input logic [7:0] tag, input int i);
      return {tag, 8'h5A, 8'(i), 8'hE7};
   endfunction

   // Starts and ends at a falling edge
   task automatic send_pkt(input logic [7:0] tag, input int gap,
                           input bit f_first, input bit r_first,
                           input bit f_after, input bit r_after,
                           output logic [31:0] ts_acc);
      bit got;
      client_fault = f_first;
      loss_state   = r_first;
      ts_acc       = '0;
      for (int i = 0; i < PAYW; i++) begin
         in_data  = pay_word(tag, i);
         in_valid = 1'b1;
         got      = 1'b0;
         while (!got) begin
            #1;
            if (in_ready) begin
               got = 1'b1;
               if (i == 0) ts_acc = ts_count;
            end
            @(negedge clk);
         end
         if (i == 0) begin
            client_fault = f_after;
            loss_state   = r_after;
         end
         in_valid = 1'b0;
         repeat (gap) @(negedge clk);
      end
   endtask

   task automatic wait_pkt(input int start);
      while (cap_n < start + PKTW) @(negedge clk);
      repeat (4) @(negedge clk);
      chk("R10 exact word count, no loss or extra", 32'(cap_n), 32'(start + PKTW));
   endtask

   task automatic check_pkt(input int s, input logic [15:0] seq, input bit l, input bit r,
                            input logic [31:0] ts, input logic [7:0] tag);
      logic [31:0] cw;
      cw = cap_d[s];
      chk("R2 zero nibble and reserved bits", {20'd0, cw[31:28], cw[25:18]}, 32'd0);
      chk("R2 fragment and length zero", {22'd0, cw[25:16]}, 32'd0);
      chk("R3 L flag", {31'd0, cw[27]}, {31'd0, l});
      chk("R4 R flag", {31'd0, cw[26]}, {31'd0, r});
      chk("R5 sequence", {16'd0, cw[15:0]}, {16'd0, seq});
      chk("R6 transport word", cap_d[s+1], {2'b10, 7'd0, cfg_pt, seq});
      chk("R7 timestamp", cap_d[s+2], ts);
      chk("R7 ssrc", cap_d[s+3], cfg_ssrc);
      for (int i = 0; i < PAYW; i++)
         chk("R8 payload word", cap_d[s+4+i], pay_word(tag, i));
      for (int i = 0; i < PKTW; i++)
         chk("R9 last flag", {31'd0, cap_l[s+i]}, (i == PKTW - 1) ? 32'd1 : 32'd0);
   endtask

   task automatic t_reset();
      #1;
      chk("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
      chk("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);
   endtask

   task automatic t_basic();
      logic [31:0] ts;
      int s;
      s = cap_n;
      send_pkt(8'hA1, 0, 1'b0, 1'b0, 1'b0, 1'b0, ts);
      wait_pkt(s);
      check_pkt(s, SEQ0, 1'b0, 1'b0, ts, 8'hA1);   // R1 initial sequence
   endtask

   task automatic t_flag_latch();
      logic [31:0] ts;
      int s;
      s = cap_n;
      send_pkt(8'hB2, 0, 1'b1, 1'b0, 1'b0, 1'b1, ts);
      wait_pkt(s);
      check_pkt(s, SEQ0 + 16'd1, 1'b1, 1'b0, ts, 8'hB2);   // R3 R4 sampled once
   endtask

   task automatic t_stall();
      logic [31:0] ts;
      int s;
      s = cap_n;
      cfg_pt     = 7'd127;
      cfg_ssrc   = 32'hCAFE_0042;
      stall_mode = 1'b1;
      send_pkt(8'hC3, 1, 1'b0, 1'b1, 1'b0, 1'b1, ts);
      wait_pkt(s);
      stall_mode = 1'b0;
      check_pkt(s, SEQ0 + 16'd2, 1'b0, 1'b1, ts, 8'hC3);   // R10 under stalls
   endtask

   task automatic t_wrap();
      logic [31:0] ts;
      int s;
      s = cap_n;
      cfg_pt   = 7'd100;
      cfg_ssrc = 32'h0BAD_F00D;
      send_pkt(8'hD4, 2, 1'b1, 1'b1, 1'b1, 1'b1, ts);
      wait_pkt(s);
      check_pkt(s, 16'h0000, 1'b1, 1'b1, ts, 8'hD4);   // R5 wrap to zero
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      @(negedge clk);
      t_basic();
      t_flag_latch();
      t_stall();
      t_wrap();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule